// File: doc/BRIEF.md
# Grouped Interrupt Controller with Cascaded Enables

This block gathers interrupt requests from many peripheral sources and decides when the processor core is interrupted. A request is latched as a pending flag on its rising edge. It reaches the core only if it passes four gates in sequence: a per-source peripheral enable, a per-source enable inside its group, a per-line core enable, and a single global mask. Each group of sources shares one core line. A small number of direct sources each own a core line of their own and skip the group stage.

None of the enable bits ever touch a pending flag. A request that arrives while its path is closed stays pending, and it is presented to the core as soon as every gate on its path is open again. Among the requests that pass every gate, a fixed priority picks one winner. Its core line and source index are shown on the output. The core acknowledges the winner with a one-cycle pulse. That pulse clears the winner's flag and latches a per-group acknowledge bit, which holds the group off until software clears it.

Software programs the block through a simple write-only port. The port carries a register kind code, a lane number and a data word. Lanes 0 to NUM_GRP-1 are the groups, and lane NUM_GRP holds the direct sources.

Top module: `grouped_irq_ctl`

## Requirements
- R1: A pending flag is set only on a 0-to-1 transition of its request input, sampled on the clock. A request held high does not set the flag again after the flag has been cleared. Source index g*GRP_SZ+i is member i of group g. Source index NUM_GRP*GRP_SZ+d is direct source d.
- R2: With its peripheral enable bit at 0 (kind 0), a source cannot raise irq_o. Its flag stays pending.
- R3: With its in-group enable bit at 0 (kind 1, group lanes only), a source is blocked, and the other members of its group are not affected.
- R4: A core enable bit at 0 (kind 2; bit g is group g, bit NUM_GRP+d is direct source d) blocks every source on that core line.
- R5: With the global mask set (kind 3, data bit 0 = 1 means masked), irq_o stays 0 whatever is pending.
- R6: A direct source is gated only by its peripheral enable (lane NUM_GRP, bit d), its core enable bit and the global mask. In-group enables and acknowledge bits do not apply to it.
- R7: An enable write at any level never clears a flag. A flag left pending is presented on irq_o once every gate on its path is open.
- R8: Among the fully enabled pending sources, the lowest core line wins, and within a group the lowest member index wins. Lines are numbered groups first, then direct sources. irq_line_o and irq_src_o name the winner; irq_src_o is 0 for a direct source.
- R9: An ack_i pulse while irq_o is 1 clears the winner's flag. If the winner is in a group, it also sets that group's acknowledge bit, which blocks the group until a write of kind 5 with data bit g set clears it. An ack_i pulse while irq_o is 0 has no effect.
- R10: A write of kind 4 clears the flags of the selected lane wherever a data bit is 1. A rising request edge in the same cycle wins over the clear.
- R11: After reset every flag, enable and acknowledge bit is 0, the global mask is set, and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req_i | input | NSRC (34) | Request inputs, groups first, then direct sources |
| wr_en_i | input | 1 | Register write strobe |
| wr_kind_i | input | 3 | Register kind: 0 peripheral enable, 1 in-group enable, 2 core enable, 3 global mask, 4 flag clear, 5 acknowledge clear |
| wr_lane_i | input | LW (3) | Lane for kinds 0, 1 and 4 |
| wr_data_i | input | DW (8) | Write data |
| ack_i | input | 1 | Core acknowledge pulse |
| irq_o | output | 1 | Interrupt request to the core |
| irq_line_o | output | LNW (3) | Core line of the winning request |
| irq_src_o | output | SW (3) | Member index of the winner inside its group |

## Verification
The assertions watch several relations on every cycle. A set mask keeps irq_o low, and a presented line always has its core enable set. A flag only appears after its request was high, and it only disappears after a clear or an acknowledge of that bit. An acknowledged group line sets its acknowledge bit. What a gate blocks and what it leaves alone, the priority order, and whether a masked request is later taken can only be shown by the bench's directed scenarios. Each scenario builds a specific pending pattern and then opens and closes gates around it.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef enum logic [2:0] {
      K_PEN    = 3'd0,
      K_GEN    = 3'd1,
      K_CEN    = 3'd2,
      K_GMASK  = 3'd3,
      K_FCLR   = 3'd4,
      K_ACKCLR = 3'd5
   } cfg_kind_e;
endpackage

// File: rtl/irq_edge_flags.sv
module irq_edge_flags #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o
);
   logic [N-1:0] req_q;
   logic [N-1:0] flag_q;

   for (genvar k = 0; k < N; k++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            req_q[k]  <= 1'b0;
            flag_q[k] <= 1'b0;
         end else begin
            req_q[k]  <= req_i[k];
            // a new edge outranks a clear in the same cycle
            flag_q[k] <= (req_i[k] & ~req_q[k]) | (flag_q[k] & ~clr_i[k]);
         end
      end
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/irq_lsb_pick.sv
module irq_lsb_pick #(
   parameter int W  = 8,
   parameter int IW = $clog2(W)
) (
   input  logic [W-1:0]  vec_i,
   output logic          any_o,
   output logic [IW-1:0] idx_o
);
   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec_i[i]) begin
            any_o = 1'b1;
            idx_o = IW'(i);
         end
      end
   end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
   import irq_pkg::*;
#(
   parameter int NUM_GRP = 4,
   parameter int GRP_SZ  = 8,
   parameter int NUM_DIR = 2,
   parameter int LW      = 3,
   parameter int DW      = 8,
   localparam int NGS    = NUM_GRP * GRP_SZ,
   localparam int NSRC   = NGS + NUM_DIR,
   localparam int NLINE  = NUM_GRP + NUM_DIR
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en_i,
   input  cfg_kind_e          wr_kind_i,
   input  logic [LW-1:0]      wr_lane_i,
   input  logic [DW-1:0]      wr_data_i,
   input  logic [NUM_GRP-1:0] ack_set_i,
   output logic [NSRC-1:0]    pen_o,
   output logic [NGS-1:0]     gen_o,
   output logic [NLINE-1:0]   cen_o,
   output logic               gmask_o,
   output logic [NUM_GRP-1:0] gack_o,
   output logic [NSRC-1:0]    fclr_o
);
   logic [NSRC-1:0]    pen_q;
   logic [NGS-1:0]     gen_q;
   logic [NLINE-1:0]   cen_q;
   logic               gmask_q;
   logic [NUM_GRP-1:0] gack_q;
   logic [NUM_GRP-1:0] gack_clr;

   assign gack_clr = (wr_en_i && wr_kind_i == K_ACKCLR) ? wr_data_i[NUM_GRP-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pen_q   <= '0;
         gen_q   <= '0;
         cen_q   <= '0;
         gmask_q <= 1'b1;
         gack_q  <= '0;
      end else begin
         if (wr_en_i) begin
            case (wr_kind_i)
               K_PEN: begin
                  for (int g = 0; g < NUM_GRP; g++)
                     if (int'(wr_lane_i) == g) pen_q[g*GRP_SZ +: GRP_SZ] <= wr_data_i[GRP_SZ-1:0];
                  if (int'(wr_lane_i) == NUM_GRP) pen_q[NGS +: NUM_DIR] <= wr_data_i[NUM_DIR-1:0];
               end
               K_GEN: begin
                  for (int g = 0; g < NUM_GRP; g++)
                     if (int'(wr_lane_i) == g) gen_q[g*GRP_SZ +: GRP_SZ] <= wr_data_i[GRP_SZ-1:0];
               end
               K_CEN:   cen_q   <= wr_data_i[NLINE-1:0];
               K_GMASK: gmask_q <= wr_data_i[0];
               default: ;
            endcase
         end
         // acknowledge latch: a set from the core outranks a software clear
         gack_q <= ack_set_i | (gack_q & ~gack_clr);
      end
   end

   always_comb begin
      fclr_o = '0;
      if (wr_en_i && wr_kind_i == K_FCLR) begin
         for (int g = 0; g < NUM_GRP; g++)
            if (int'(wr_lane_i) == g) fclr_o[g*GRP_SZ +: GRP_SZ] = wr_data_i[GRP_SZ-1:0];
         if (int'(wr_lane_i) == NUM_GRP) fclr_o[NGS +: NUM_DIR] = wr_data_i[NUM_DIR-1:0];
      end
   end

   assign pen_o   = pen_q;
   assign gen_o   = gen_q;
   assign cen_o   = cen_q;
   assign gmask_o = gmask_q;
   assign gack_o  = gack_q;
endmodule

// File: rtl/grouped_irq_ctl.sv
module grouped_irq_ctl
   import irq_pkg::*;
#(
   parameter int NUM_GRP = 4,
   parameter int GRP_SZ  = 8,
   parameter int NUM_DIR = 2,
   localparam int NGS    = NUM_GRP * GRP_SZ,
   localparam int NSRC   = NGS + NUM_DIR,
   localparam int NLINE  = NUM_GRP + NUM_DIR,
   localparam int LW     = $clog2(NUM_GRP + 1),
   localparam int LNW    = $clog2(NLINE),
   localparam int SW     = $clog2(GRP_SZ),
   localparam int DW     = (GRP_SZ > NLINE) ? GRP_SZ : NLINE
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_req_i,
   input  logic            wr_en_i,
   input  logic [2:0]      wr_kind_i,
   input  logic [LW-1:0]   wr_lane_i,
   input  logic [DW-1:0]   wr_data_i,
   input  logic            ack_i,
   output logic            irq_o,
   output logic [LNW-1:0]  irq_line_o,
   output logic [SW-1:0]   irq_src_o
);
   if (NUM_GRP < 1) begin : g_bad_grp
      $error("grouped_irq_ctl: NUM_GRP must be at least 1");
   end
   if (GRP_SZ < 2) begin : g_bad_sz
      $error("grouped_irq_ctl: GRP_SZ must be at least 2");
   end
   if (NUM_DIR < 1) begin : g_bad_dir
      $error("grouped_irq_ctl: NUM_DIR must be at least 1");
   end

   logic [NSRC-1:0]    flag_q;
   logic [NSRC-1:0]    clr_vec;
   logic [NSRC-1:0]    fclr;
   logic [NSRC-1:0]    ack_clr;
   logic [NSRC-1:0]    pen_q;
   logic [NGS-1:0]     gen_q;
   logic [NLINE-1:0]   cen_q;
   logic               gmask_q;
   logic [NUM_GRP-1:0] gack_q;
   logic [NUM_GRP-1:0] ack_set;
   logic [NSRC-1:0]    qual;
   logic [NLINE-1:0]   line_req;
   logic [NLINE-1:0]   line_vec;
   logic [NUM_GRP-1:0] g_any;
   logic [SW-1:0]      g_idx [NUM_GRP];
   logic [LNW-1:0]     win_line;
   logic               win_any;
   logic               ack_fire;

   irq_cfg_regs #(
      .NUM_GRP(NUM_GRP), .GRP_SZ(GRP_SZ), .NUM_DIR(NUM_DIR), .LW(LW), .DW(DW)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en_i),
      .wr_kind_i (cfg_kind_e'(wr_kind_i)),
      .wr_lane_i (wr_lane_i),
      .wr_data_i (wr_data_i),
      .ack_set_i (ack_set),
      .pen_o     (pen_q),
      .gen_o     (gen_q),
      .cen_o     (cen_q),
      .gmask_o   (gmask_q),
      .gack_o    (gack_q),
      .fclr_o    (fclr)
   );

   assign clr_vec = fclr | ack_clr;

   irq_edge_flags #(.N(NSRC)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (src_req_i),
      .clr_i  (clr_vec),
      .flag_o (flag_q)
   );

   // stage 1: peripheral enable
   assign qual = flag_q & pen_q;

   // stage 2: per-source group enable, then the acknowledge latch per group
   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      irq_lsb_pick #(.W(GRP_SZ), .IW(SW)) u_pick (
         .vec_i (qual[g*GRP_SZ +: GRP_SZ] & gen_q[g*GRP_SZ +: GRP_SZ]),
         .any_o (g_any[g]),
         .idx_o (g_idx[g])
      );
      assign line_req[g] = g_any[g] & ~gack_q[g];
   end

   for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
      assign line_req[NUM_GRP + d] = qual[NGS + d];
   end

   // stages 3 and 4: core enable and global mask
   assign line_vec = line_req & cen_q & {NLINE{~gmask_q}};

   irq_lsb_pick #(.W(NLINE), .IW(LNW)) u_line_pick (
      .vec_i (line_vec),
      .any_o (win_any),
      .idx_o (win_line)
   );

   assign irq_o      = win_any;
   assign irq_line_o = win_line;
   assign ack_fire   = ack_i & win_any;

   always_comb begin
      irq_src_o = '0;
      ack_clr   = '0;
      ack_set   = '0;
      for (int g = 0; g < NUM_GRP; g++) begin
         if (int'(win_line) == g) begin
            irq_src_o = g_idx[g];
            if (ack_fire) begin
               ack_clr[g*GRP_SZ + int'(g_idx[g])] = 1'b1;
               ack_set[g] = 1'b1;
            end
         end
      end
      for (int d = 0; d < NUM_DIR; d++) begin
         if (ack_fire && int'(win_line) == NUM_GRP + d) ack_clr[NGS + d] = 1'b1;
      end
   end
endmodule

// File: rtl/irq_ctl_checker.sv
module irq_ctl_checker #(
   parameter int NSRC    = 34,
   parameter int NLINE   = 6,
   parameter int NUM_GRP = 4,
   parameter int LNW     = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NSRC-1:0]    src_req,
   input logic [NSRC-1:0]    flags,
   input logic [NSRC-1:0]    clr_vec,
   input logic               gmask,
   input logic [NLINE-1:0]   cen,
   input logic [NUM_GRP-1:0] gack,
   input logic               ack_i,
   input logic               irq_o,
   input logic [LNW-1:0]     irq_line
);
   assert_mask_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      gmask |-> !irq_o);

   assert_line_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> cen[irq_line]);

   assert_flag_from_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (flags & ~$past(flags) & ~$past(src_req)) == '0);

   assert_enable_keeps_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(flags) & ~flags & ~$past(clr_vec)) == '0);

   assert_ack_latches_group_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && irq_o && int'(irq_line) < NUM_GRP) |=> gack[$past(irq_line)]);
endmodule

bind grouped_irq_ctl irq_ctl_checker #(
   .NSRC(NSRC), .NLINE(NLINE), .NUM_GRP(NUM_GRP), .LNW(LNW)
) u_irq_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .src_req  (src_req_i),
   .flags    (flag_q),
   .clr_vec  (clr_vec),
   .gmask    (gmask_q),
   .cen      (cen_q),
   .gack     (gack_q),
   .ack_i    (ack_i),
   .irq_o    (irq_o),
   .irq_line (irq_line_o)
);

// File: tb/test_grouped_irq_ctl.sv
module test_grouped_irq_ctl;
   localparam int NSRC = 34;
   localparam int DIR0 = 32;
   localparam int K_PEN = 0, K_GEN = 1, K_CEN = 2, K_GMASK = 3, K_FCLR = 4, K_ACKCLR = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] src_req = '0;
   logic            wr_en = 1'b0;
   logic [2:0]      wr_kind = '0;
   logic [2:0]      wr_lane = '0;
   logic [7:0]      wr_data = '0;
   logic            ack = 1'b0;
   logic            irq;
   logic [2:0]      irq_line;
   logic [2:0]      irq_src;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   grouped_irq_ctl i_grouped_irq_ctl (
      .clk(clk), .rst_n(rst_n), .src_req_i(src_req),
      .wr_en_i(wr_en), .wr_kind_i(wr_kind), .wr_lane_i(wr_lane), .wr_data_i(wr_data),
      .ack_i(ack), .irq_o(irq), .irq_line_o(irq_line), .irq_src_o(irq_src)
   );

   task automatic chk(string rq, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", rq, act, exp);
      end
   endtask

   task automatic exp_irq(string rq, bit on, int line = 0, int src = 0);
      chk({rq, " irq"}, int'(irq), int'(on));
      if (on) begin
         chk({rq, " line"}, int'(irq_line), line);
         chk({rq, " src"}, int'(irq_src), src);
      end
   endtask

   task automatic wr(int kind, int lane, int data);
      wr_en = 1'b1; wr_kind = 3'(kind); wr_lane = 3'(lane); wr_data = 8'(data);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse(logic [NSRC-1:0] m);
      src_req = src_req | m;
      @(negedge clk);
      src_req = src_req & ~m;
      @(negedge clk);
   endtask

   task automatic do_ack();
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; src_req = '0; wr_en = 1'b0; ack = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic open_all();
      for (int g = 0; g < 4; g++) begin
         wr(K_PEN, g, 8'hff);
         wr(K_GEN, g, 8'hff);
      end
      wr(K_PEN, 4, 3);
      wr(K_CEN, 0, 8'h3f);
      wr(K_GMASK, 0, 0);
   endtask

   function automatic logic [NSRC-1:0] bit_at(int i);
      return NSRC'(1) << i;
   endfunction

   task automatic t_reset();
      do_reset();
      exp_irq("R11 reset", 1'b0);
      for (int g = 0; g < 4; g++) begin
         wr(K_PEN, g, 8'hff);
         wr(K_GEN, g, 8'hff);
      end
      wr(K_CEN, 0, 8'h3f);
      pulse(bit_at(0*8 + 4));
      exp_irq("R11 mask set after reset", 1'b0);
      wr(K_GMASK, 0, 0);
      exp_irq("R7 pending taken after unmask", 1'b1, 0, 4);
   endtask

   task automatic t_edge();
      do_reset(); open_all();
      src_req[1*8 + 3] = 1'b1;
      @(negedge clk);
      exp_irq("R1 edge sets flag", 1'b1, 1, 3);
      do_ack();
      wr(K_ACKCLR, 0, 8'h02);
      exp_irq("R1 held level no retrigger", 1'b0);
      src_req[1*8 + 3] = 1'b0;
      @(negedge clk);
      pulse(bit_at(1*8 + 3));
      exp_irq("R1 new edge sets flag", 1'b1, 1, 3);
   endtask

   task automatic t_pen();
      do_reset(); open_all();
      wr(K_PEN, 2, 0);
      pulse(bit_at(2*8 + 5));
      exp_irq("R2 peripheral enable blocks", 1'b0);
      wr(K_PEN, 2, 8'hff);
      exp_irq("R2 pending kept", 1'b1, 2, 5);
   endtask

   task automatic t_gen();
      do_reset(); open_all();
      wr(K_GEN, 0, 8'hfb);
      pulse(bit_at(2) | bit_at(6));
      exp_irq("R3 only one member blocked", 1'b1, 0, 6);
      wr(K_GEN, 0, 8'hff);
      exp_irq("R3 reenabled member wins", 1'b1, 0, 2);
   endtask

   task automatic t_cen();
      do_reset(); open_all();
      wr(K_CEN, 0, 8'h3d);
      pulse(bit_at(1*8 + 0) | bit_at(1*8 + 7));
      exp_irq("R4 core enable blocks group", 1'b0);
      pulse(bit_at(3*8 + 4));
      exp_irq("R4 other group passes", 1'b1, 3, 4);
      wr(K_CEN, 0, 8'h3f);
      exp_irq("R4 group reenabled", 1'b1, 1, 0);
   endtask

   task automatic t_mask();
      do_reset(); open_all();
      pulse(bit_at(DIR0 + 1));
      exp_irq("R5 direct unmasked", 1'b1, 5, 0);
      wr(K_GMASK, 0, 1);
      exp_irq("R5 mask blocks", 1'b0);
      wr(K_GMASK, 0, 0);
      exp_irq("R7 mask release", 1'b1, 5, 0);
   endtask

   task automatic t_direct();
      do_reset(); open_all();
      for (int g = 0; g < 4; g++) wr(K_GEN, g, 0);
      wr(K_GEN, 4, 0);
      pulse(bit_at(DIR0));
      exp_irq("R6 direct ignores group enables", 1'b1, 4, 0);
      wr(K_PEN, 4, 2);
      exp_irq("R6 direct peripheral enable", 1'b0);
      wr(K_PEN, 4, 3);
      wr(K_CEN, 0, 8'h2f);
      exp_irq("R6 direct core enable", 1'b0);
      wr(K_CEN, 0, 8'h3f);
      do_ack();
      exp_irq("R6 direct ack clears", 1'b0);
      pulse(bit_at(DIR0));
      exp_irq("R6 direct no ack latch", 1'b1, 4, 0);
   endtask

   task automatic t_prio();
      do_reset(); open_all();
      pulse(bit_at(2*8 + 1) | bit_at(3*8 + 0) | bit_at(DIR0));
      exp_irq("R8 lowest line first", 1'b1, 2, 1);
      do_ack();
      exp_irq("R8 next line", 1'b1, 3, 0);
      do_ack();
      exp_irq("R8 direct after groups", 1'b1, 4, 0);
      do_ack();
      exp_irq("R8 all served", 1'b0);
   endtask

   task automatic t_ack();
      do_reset(); open_all();
      pulse(bit_at(3) | bit_at(5));
      exp_irq("R9 winner", 1'b1, 0, 3);
      do_ack();
      exp_irq("R9 group held by ack bit", 1'b0);
      wr(K_ACKCLR, 0, 8'h01);
      exp_irq("R9 ack clear releases", 1'b1, 0, 5);
      wr(K_GMASK, 0, 1);
      do_ack();
      wr(K_GMASK, 0, 0);
      exp_irq("R9 ack without irq ignored", 1'b1, 0, 5);
   endtask

   task automatic t_fclr();
      do_reset(); open_all();
      pulse(bit_at(1*8 + 2) | bit_at(1*8 + 4));
      wr(K_FCLR, 1, 8'h04);
      exp_irq("R10 clear one flag", 1'b1, 1, 4);
      wr(K_FCLR, 1, 8'h10);
      exp_irq("R10 all cleared", 1'b0);
      src_req[1*8 + 6] = 1'b1;
      wr(K_FCLR, 1, 8'h40);
      src_req[1*8 + 6] = 1'b0;
      exp_irq("R10 edge beats clear", 1'b1, 1, 6);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_edge();
      t_pen();
      t_gen();
      t_cen();
      t_mask();
      t_direct();
      t_prio();
      t_ack();
      t_fclr();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule